// File: doc/BRIEF.md
# Event-Based Branch Control Unit

This unit holds the three registers that let user-level software take a lightweight branch on hardware events in a 64-bit processor: a status/control register (enables, global arm bit, occurred flags), a return-address register and a handler-address register. When an external event or a performance-monitor event arrives while the matching enable and the global arm bit are set, the unit redirects fetch to the handler address. It saves the interrupted next-instruction address, disarms itself and records which event fired.

The unit also executes the return instruction that ends a handler. That instruction redirects fetch to the saved return address, and its one-bit operand decides whether the global arm bit is set again. The return is refused with an illegal-instruction flag when either of two reserved status bits is nonzero. In 32-bit mode the return target is cut to its low 32 bits. All outputs are registered, so a redirect or exception appears one clock after the cycle that caused it. Bit positions below use LSB-0 numbering (bit 63 is the most significant bit).

Top module: `ebb_ctrl`

## Requirements
- R1: After synchronous reset all three registers read zero and redirect_valid, redirect_addr and illegal_insn are low.
- R2: An external event is taken when status bit 63 (global arm) and bit 33 (external enable) are both 1. A monitor event is taken when bit 63 and bit 32 (monitor enable) are both 1. A taken event gives redirect_valid with redirect_addr equal to the handler register on the next cycle, and any other event is ignored.
- R3: A taken event clears status bit 63. The same edge sets bit 1 for an external event or bit 0 for a monitor event.
- R4: A taken event loads the return register with nia, its two low bits forced to zero.
- R5: If both events are taken in one cycle, the monitor event wins: a single redirect is issued, and only bit 0 of the occurred flags is set.
- R6: The return instruction is recognised only when insn_valid is 1, insn_word[31:26] = 010011 and insn_word[10:1] = 0010010010. Any other word has no effect.
- R7: A legal return in 64-bit mode (mode64 = 1) redirects on the next cycle to the full return register.
- R8: A legal return sets status bit 63 when insn_word[11] is 1 and clears it when insn_word[11] is 0. Other status bits are left as they are.
- R9: A legal return in 32-bit mode (mode64 = 0) redirects to the low 32 bits of the return register, with the upper 32 bits zero.
- R10: When status bits 31:30 are not 00, a return raises illegal_insn on the next cycle instead of redirecting, and leaves the status register unchanged.
- R11: Bits 1:0 of the return and handler registers always read as zero.
- R12: A taken event in the same cycle as a return squashes the return. A register write in a cycle with a taken event or a decoded return is dropped.
- R13: reg_rd_data shows, one cycle after reg_rd_sel is driven, the selected register: 0 status, 1 return, 2 handler, 3 zero. Writes use the same select codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register written (0 status, 1 return, 2 handler) |
| reg_wr_data | input | 64 | Write data |
| reg_rd_sel | input | 2 | Register read |
| reg_rd_data | output | 64 | Registered read data |
| ext_evt | input | 1 | External event request |
| pm_evt | input | 1 | Performance-monitor event request |
| insn_valid | input | 1 | A decoded instruction is presented |
| insn_word | input | 32 | Instruction word |
| nia | input | 64 | Next-instruction address |
| mode64 | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| redirect_valid | output | 1 | Fetch redirect request |
| redirect_addr | output | 64 | Fetch redirect target |
| illegal_insn | output | 1 | Illegal-instruction program exception |

## Verification
The bench targets the enable gating and arbitration corners. An event with its own enable clear, or with the arm bit clear, must not redirect, and a design that ignored either gate would jump into the handler unarmed. Simultaneous events must give one redirect with only the monitor flag set, and a design that honoured both would mark two occurred flags. The bench also runs a return with a reserved bit set, which a careless design would still execute. It checks the 32-bit-mode return, where leaking high address bits would send fetch far away. It drives an event and a return together, where a design that let the return through would re-arm the enable while the handler is still being entered.

// File: rtl/ebb_pkg.sv
package ebb_pkg;
  // status bit positions, LSB-0 numbering of a 64-bit register
  localparam int BIT_GE   = 63;
  localparam int BIT_EXT  = 33;
  localparam int BIT_PM   = 32;
  localparam int BIT_RSVH = 31;
  localparam int BIT_RSVL = 30;
  localparam int BIT_EXTO = 1;
  localparam int BIT_PMO  = 0;

  typedef enum logic [1:0] {
    SEL_STATUS  = 2'd0,
    SEL_RETURN  = 2'd1,
    SEL_HANDLER = 2'd2,
    SEL_NONE    = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_PM   = 2'd2
  } evt_src_e;
endpackage

// File: rtl/ebb_decode.sv
module ebb_decode #(
  parameter int ILEN = 32
) (
  input  logic            valid,
  input  logic [ILEN-1:0] word,
  output logic            is_ret,
  output logic            ret_s
);
  localparam logic [5:0] PRIMARY = 6'b010011;
  localparam logic [9:0] EXTOP   = 10'b0010010010;
  localparam int S_POS = ILEN - 21;

  always_comb begin
    is_ret = valid && (word[ILEN-1:ILEN-6] == PRIMARY) && (word[10:1] == EXTOP);
    ret_s  = word[S_POS];
  end
endmodule

// File: rtl/ebb_arbiter.sv
module ebb_arbiter
  import ebb_pkg::*;
(
  input  logic     ext_evt,
  input  logic     pm_evt,
  input  logic     armed,
  input  logic     ext_en,
  input  logic     pm_en,
  output logic     take,
  output evt_src_e src
);
  logic ext_hit, pm_hit;

  always_comb begin
    ext_hit = armed && ext_en && ext_evt;
    pm_hit  = armed && pm_en && pm_evt;
    take    = ext_hit || pm_hit;
    if (pm_hit)       src = SRC_PM;
    else if (ext_hit) src = SRC_EXT;
    else              src = SRC_NONE;
  end
endmodule

// File: rtl/ebb_regs.sv
module ebb_regs
  import ebb_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [XLEN-1:0] wr_data,
  input  logic            busy,
  input  logic            take,
  input  evt_src_e        src,
  input  logic [XLEN-1:0] nia,
  input  logic            ret_go,
  input  logic            ret_s,
  output logic [XLEN-1:0] status_q,
  output logic [XLEN-1:0] ret_q,
  output logic [XLEN-1:0] hand_q
);
  localparam int ALIGN = 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      ret_q    <= '0;
      hand_q   <= '0;
    end else begin
      if (wr_en && !busy) begin
        case (reg_sel_e'(wr_sel))
          SEL_STATUS:  status_q <= wr_data;
          SEL_RETURN:  ret_q    <= {wr_data[XLEN-1:ALIGN], {ALIGN{1'b0}}};
          SEL_HANDLER: hand_q   <= {wr_data[XLEN-1:ALIGN], {ALIGN{1'b0}}};
          default: ;
        endcase
      end
      if (take) begin
        status_q[BIT_GE] <= 1'b0;
        if (src == SRC_PM) status_q[BIT_PMO]  <= 1'b1;
        else               status_q[BIT_EXTO] <= 1'b1;
        ret_q <= {nia[XLEN-1:ALIGN], {ALIGN{1'b0}}};
      end
      if (ret_go) status_q[BIT_GE] <= ret_s;
    end
  end
endmodule

// File: rtl/ebb_ctrl.sv
module ebb_ctrl
  import ebb_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int ILEN = 32,
  parameter int NARROW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_wr_en,
  input  logic [1:0]      reg_wr_sel,
  input  logic [XLEN-1:0] reg_wr_data,
  input  logic [1:0]      reg_rd_sel,
  output logic [XLEN-1:0] reg_rd_data,
  input  logic            ext_evt,
  input  logic            pm_evt,
  input  logic            insn_valid,
  input  logic [ILEN-1:0] insn_word,
  input  logic [XLEN-1:0] nia,
  input  logic            mode64,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_addr,
  output logic            illegal_insn
);
  logic [XLEN-1:0] status_q, ret_q, hand_q;
  logic            is_ret, ret_s, take, ret_req, ret_bad, ret_go, busy;
  evt_src_e        src;
  logic [XLEN-1:0] ret_target;
  logic            unused_bits;

  assign unused_bits = ^{insn_word[ILEN-7:12], insn_word[0], nia[1:0]};

  ebb_decode #(.ILEN(ILEN)) u_dec (
    .valid(insn_valid), .word(insn_word), .is_ret(is_ret), .ret_s(ret_s)
  );

  ebb_arbiter u_arb (
    .ext_evt(ext_evt), .pm_evt(pm_evt), .armed(status_q[BIT_GE]),
    .ext_en(status_q[BIT_EXT]), .pm_en(status_q[BIT_PM]),
    .take(take), .src(src)
  );

  always_comb begin
    ret_req = is_ret && !take;
    ret_bad = ret_req && (status_q[BIT_RSVH:BIT_RSVL] != 2'b00);
    ret_go  = ret_req && !ret_bad;
    busy    = take || is_ret;
    ret_target = mode64 ? ret_q : {{(XLEN-NARROW){1'b0}}, ret_q[NARROW-1:0]};
  end

  ebb_regs #(.XLEN(XLEN)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .wr_sel(reg_wr_sel),
    .wr_data(reg_wr_data), .busy(busy), .take(take), .src(src), .nia(nia),
    .ret_go(ret_go), .ret_s(ret_s),
    .status_q(status_q), .ret_q(ret_q), .hand_q(hand_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_valid <= 1'b0;
      redirect_addr  <= '0;
      illegal_insn   <= 1'b0;
      reg_rd_data    <= '0;
    end else begin
      redirect_valid <= take || ret_go;
      illegal_insn   <= ret_bad;
      if (take)        redirect_addr <= hand_q;
      else if (ret_go) redirect_addr <= ret_target;
      else             redirect_addr <= '0;
      case (reg_sel_e'(reg_rd_sel))
        SEL_STATUS:  reg_rd_data <= status_q;
        SEL_RETURN:  reg_rd_data <= ret_q;
        SEL_HANDLER: reg_rd_data <= hand_q;
        default:     reg_rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/ebb_ctrl_chk.sv
module ebb_ctrl_chk
  import ebb_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            ext_evt,
  input logic            pm_evt,
  input logic            mode64,
  input logic            redirect_valid,
  input logic [XLEN-1:0] redirect_addr,
  input logic            illegal_insn,
  input logic [XLEN-1:0] status,
  input logic            ret_go
);
  // R10
  excl_out_chk: assert property (@(posedge clk) disable iff (rst)
    !(redirect_valid && illegal_insn));

  // R11
  target_align_chk: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |-> redirect_addr[1:0] == 2'b00);

  // R3
  arm_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ((ext_evt && status[BIT_EXT]) || (pm_evt && status[BIT_PM])) && status[BIT_GE]
      |=> !status[BIT_GE]);

  // R9
  narrow_ret_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_go && !mode64) |=> redirect_valid && redirect_addr[XLEN-1:32] == '0);

  // R10
  illegal_keep_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_insn |-> status == $past(status));
endmodule

bind ebb_ctrl ebb_ctrl_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .ext_evt(ext_evt), .pm_evt(pm_evt), .mode64(mode64),
  .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
  .illegal_insn(illegal_insn), .status(status_q), .ret_go(ret_go)
);

// File: tb/sim_ebb_ctrl.sv
`timescale 1ns/1ps
module sim_ebb_ctrl;
  localparam logic [63:0] GE   = 64'h8000_0000_0000_0000;
  localparam logic [63:0] EE   = 64'h0000_0002_0000_0000;
  localparam logic [63:0] PME  = 64'h0000_0001_0000_0000;
  localparam logic [63:0] RSV  = 64'h0000_0000_4000_0000;
  localparam logic [63:0] EEO  = 64'h2;
  localparam logic [63:0] PMEO = 64'h1;
  localparam logic [63:0] RR   = 64'h1234_5678_9ABC_DEF0;
  localparam logic [63:0] HR   = 64'h0000_7000_0000_1000;
  localparam logic [63:0] NIA  = 64'h0000_0000_0040_0108;
  localparam logic [31:0] RET1 = 32'h4C00_0924;
  localparam logic [31:0] RET0 = 32'h4C00_0124;
  localparam logic [31:0] BADW = 32'h4C00_0A24;

  typedef struct packed {
    logic [63:0] bescr;
    logic [31:0] word;
    logic ext, pm, valid, m64;
    logic exp_v;
    logic [63:0] exp_a;
    logic exp_ill;
    logic [63:0] exp_st;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{GE|EE,  RET0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, HR, 1'b0, EE|EEO},
    '{EE,     RET0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 64'h0, 1'b0, EE},
    '{GE|PME, RET0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, HR, 1'b0, PME|PMEO},
    '{GE,     RET0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 64'h0, 1'b0, GE},
    '{GE|EE|PME, RET0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, HR, 1'b0, EE|PME|PMEO},
    '{EE,     RET1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, RR, 1'b0, GE|EE},
    '{GE|PME, RET0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 64'h0000_0000_9ABC_DEF0, 1'b0, PME},
    '{GE|RSV, RET1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 64'h0, 1'b1, GE|RSV},
    '{64'h0,  BADW, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 64'h0, 1'b0, 64'h0},
    '{64'h0,  RET1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 64'h0, 1'b0, 64'h0}
  };
  localparam string VTAG [NV] = '{"R2 R3", "R2", "R2 R3", "R2", "R5",
                                  "R7 R8", "R9 R8", "R10", "R6", "R6"};

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr_en = 1'b0;
  logic [1:0] reg_wr_sel = 2'd0, reg_rd_sel = 2'd0;
  logic [63:0] reg_wr_data = '0, reg_rd_data, nia = '0, redirect_addr;
  logic ext_evt = 1'b0, pm_evt = 1'b0, insn_valid = 1'b0, mode64 = 1'b1;
  logic [31:0] insn_word = '0;
  logic redirect_valid, illegal_insn;
  int checks = 0, fails = 0;
  logic [63:0] rv;

  always #2.5 clk = ~clk;

  ebb_ctrl u0 (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .reg_wr_data(reg_wr_data), .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
    .ext_evt(ext_evt), .pm_evt(pm_evt), .insn_valid(insn_valid),
    .insn_word(insn_word), .nia(nia), .mode64(mode64),
    .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
    .illegal_insn(illegal_insn)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [63:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [63:0] d);
    @(negedge clk);
    reg_rd_sel = sel;
    @(negedge clk);
    d = reg_rd_data;
  endtask

  task automatic clear_in();
    ext_evt = 1'b0; pm_evt = 1'b0; insn_valid = 1'b0; mode64 = 1'b1;
    reg_wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", {63'b0, redirect_valid}, 64'h0);
    chk("R1 illegal", {63'b0, illegal_insn}, 64'h0);
    rst = 1'b0;
    rd(2'd0, rv); chk("R1 status", rv, 64'h0);
    rd(2'd1, rv); chk("R1 return", rv, 64'h0);
    rd(2'd2, rv); chk("R1 handler", rv, 64'h0);
    chk("R1 addr", redirect_addr, 64'h0);

    for (int i = 0; i < NV; i++) begin
      wr(2'd1, RR);
      wr(2'd2, HR);
      wr(2'd0, VEC[i].bescr);
      @(negedge clk);
      ext_evt = VEC[i].ext; pm_evt = VEC[i].pm; insn_valid = VEC[i].valid;
      insn_word = VEC[i].word; mode64 = VEC[i].m64; nia = NIA;
      @(negedge clk);
      chk({VTAG[i], " valid"}, {63'b0, redirect_valid}, {63'b0, VEC[i].exp_v});
      chk({VTAG[i], " addr"}, redirect_addr, VEC[i].exp_a);
      chk({VTAG[i], " illegal"}, {63'b0, illegal_insn}, {63'b0, VEC[i].exp_ill});
      clear_in();
      @(negedge clk);
      chk({VTAG[i], " single pulse"}, {63'b0, redirect_valid}, 64'h0);
      rd(2'd0, rv);
      chk({VTAG[i], " status"}, rv, VEC[i].exp_st);
    end

    // R4 return register capture
    wr(2'd0, GE | EE);
    @(negedge clk);
    ext_evt = 1'b1; nia = 64'hABCD_0000_0000_1237;
    @(negedge clk);
    clear_in();
    rd(2'd1, rv); chk("R4 saved nia", rv, 64'hABCD_0000_0000_1234);

    // R11 alignment of written addresses
    wr(2'd2, 64'h0000_0000_0000_2003);
    rd(2'd2, rv); chk("R11 handler low bits", rv, 64'h0000_0000_0000_2000);
    wr(2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(2'd1, rv); chk("R11 return low bits", rv, 64'hFFFF_FFFF_FFFF_FFFC);

    // R13 select 3 reads zero
    rd(2'd3, rv); chk("R13 unused select", rv, 64'h0);

    // R12 event squashes a return in the same cycle
    wr(2'd1, RR); wr(2'd2, HR); wr(2'd0, GE | EE);
    @(negedge clk);
    ext_evt = 1'b1; insn_valid = 1'b1; insn_word = RET1; nia = NIA;
    @(negedge clk);
    chk("R12 event wins addr", redirect_addr, HR);
    clear_in();
    rd(2'd0, rv); chk("R12 return squashed", rv, EE | EEO);

    // R12 write dropped during a taken event
    wr(2'd0, GE | PME);
    @(negedge clk);
    pm_evt = 1'b1; reg_wr_en = 1'b1; reg_wr_sel = 2'd2; reg_wr_data = 64'h5550;
    @(negedge clk);
    clear_in();
    rd(2'd2, rv); chk("R12 write ignored", rv, HR);

    finish_run();
  end
endmodule